// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO

This block is a first-in first-out buffer between two unrelated clock domains. Words enter on a write port timed by `wclk` and leave on a read port timed by `rclk`. Either clock may run faster, slower or in step with the other. Each port moves a word only when its active-low select is low and its enable is high at a rising edge of its own clock. The read data path has an output-enable that follows the read select, so a bus owner can tri-state or mux the data.

A static mode input, held at its level from reset onward, picks one of two timing behaviours. The status outputs `w_stat` and `r_stat` mean different things in each mode:

- **Standard mode**: `r_stat` reports empty and `w_stat` reports full. A read request is needed before a word shows up on `r_data`.
- **Fall-through mode**: `r_stat` reports that a valid word is waiting on `r_data`, and `w_stat` reports that a write would be accepted. The oldest word moves onto the output by itself, and a read request takes it away.

Pointers cross between domains in Gray code through two-flop synchronizers. Because of this, a flag that would release a blocked port does so a few cycles late, but it never reports space or data that is not there.

Top module: `dmode_async_fifo`

## Requirements
- R1: After reset in standard mode (`mode_std`=1), `r_stat`=1 and `w_stat`=0. After reset in fall-through mode (`mode_std`=0), `r_stat`=0 and `w_stat`=1.
- R2: In standard mode, words are read out in the order they were accepted. `r_stat`=1 whenever no unread word remains. With the read port idle, `w_stat` goes to 1 on the wclk edge that accepts the DEPTH-th word.
- R3: In fall-through mode, the oldest word appears on `r_data` with `r_stat`=1 without any read request. It stays there unchanged until a read takes it.
- R4: A write while the FIFO is full (standard `w_stat`=1, fall-through `w_stat`=0) is ignored. No stored word is lost or added.
- R5: A read while no word is available (standard `r_stat`=1, fall-through `r_stat`=0) is ignored. The read position does not move.
- R6: A port transfers a word only at a rising edge of its own clock with its select low and its enable high. Otherwise the edge has no effect.
- R7: `r_oe` is 1 exactly while `r_cs_n` is 0.
- R8: In fall-through mode, the word held on the output counts toward the capacity. At most DEPTH words are accepted before any read, and `w_stat` then stays 0.
- R9: In standard mode, `r_data` changes only on an rclk edge that accepts a read. The word appears on `r_data` right after that edge.
- R10: With unrelated clock periods and reads and writes running at the same time, every accepted word comes out exactly once and in order, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_std | input | 1 | 1 selects standard mode, 0 selects fall-through mode; static from reset on |
| wclk | input | 1 | Write port clock |
| wrst_n | input | 1 | Synchronous active-low reset, write domain |
| w_cs_n | input | 1 | Write select, active low |
| w_en | input | 1 | Write enable, active high |
| w_data | input | DW | Word to write |
| w_stat | output | 1 | Standard: full; fall-through: room available |
| rclk | input | 1 | Read port clock |
| rrst_n | input | 1 | Synchronous active-low reset, read domain |
| r_cs_n | input | 1 | Read select, active low |
| r_en | input | 1 | Read enable, active high |
| r_data | output | DW | Read data register |
| r_oe | output | 1 | Output enable for `r_data` |
| r_stat | output | 1 | Standard: empty; fall-through: output word valid |

## Verification
The failures to watch for are internal errors that only show up at the ports. A read pointer that slips past an empty FIFO shows up as a wrong word on `r_data` at the very next read. A write pointer that moves while full shows up later, as a lost or duplicated word once the FIFO is drained. A fall-through output register that fails to count toward capacity shows up at once: the write port accepts DEPTH+1 words. The scoreboard therefore compares every word as it is read. It drains the FIFO after each full or empty abuse, so a corrupted pointer surfaces within one drain.

// File: rtl/dmf_pkg.sv
// Shared definitions for the dual-mode dual-clock FIFO.
// Assumes: nothing beyond IEEE 1800-2017.
package dmf_pkg;
    typedef enum logic {
        MODE_FWFT = 1'b0,
        MODE_STD  = 1'b1
    } dmf_mode_e;
endpackage

// File: rtl/dmf_sync2.sv
// Two-flop synchronizer for a Gray-coded pointer bus.
// Assumes: the input changes at most one bit per source clock.
module dmf_sync2 #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Capture the foreign value, then re-register it once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/dmf_ram.sv
// Storage array: synchronous write on wclk, combinational read.
// Assumes: the read address points at a slot not being written.
module dmf_ram #(
    parameter int DW = 32,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int SLOTS = 1 << AW;

    logic [DW-1:0] cells [SLOTS];

    // Store one word per accepted write.
    always_ff @(posedge wclk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/dmf_wr_ctl.sv
// Write-domain control: write pointer, full detection, status flag.
// Assumes: AW >= 2; rgray_sync is the reader's committed pointer in Gray code.
module dmf_wr_ctl #(
    parameter int AW = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_std,
    input  logic        cs_n,
    input  logic        en,
    input  logic [AW:0] rgray_sync,
    output logic        we,
    output logic [AW-1:0] waddr,
    output logic [AW:0] wbin,
    output logic [AW:0] wgray,
    output logic        flag
);
    localparam int PW = AW + 1;

    logic [PW-1:0] wbin_q, wgray_q, wbin_nxt;
    logic          full, fire;

    // Full when the write pointer is one lap ahead of the read pointer.
    always_comb begin
        full     = (wgray_q == {~rgray_sync[PW-1:PW-2], rgray_sync[PW-3:0]});
        fire     = !cs_n && en && !full;
        wbin_nxt = wbin_q + PW'(fire);
    end

    // Advance the binary pointer and its Gray image together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin_q  <= '0;
            wgray_q <= '0;
        end else begin
            wbin_q  <= wbin_nxt;
            wgray_q <= wbin_nxt ^ (wbin_nxt >> 1);
        end
    end

    assign we    = fire;
    assign waddr = wbin_q[AW-1:0];
    assign wbin  = wbin_q;
    assign wgray = wgray_q;
    assign flag  = mode_std ? full : !full;
endmodule

// File: rtl/dmf_rd_ctl.sv
// Read-domain control: fetch pointer, output register, status flag.
// In fall-through mode the word in the output register is not yet
// committed, so the pointer sent to the writer lags the fetch pointer.
// Assumes: wgray_sync is the writer pointer in Gray code; mode_std static.
module dmf_rd_ctl #(
    parameter int DW = 32,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_std,
    input  logic          cs_n,
    input  logic          en,
    input  logic [AW:0]   wgray_sync,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output logic [AW:0]   rgray,
    output logic          flag
);
    localparam int PW = AW + 1;

    logic [PW-1:0] fbin_q, fbin_nxt, cbin_nxt, rgray_q;
    logic          ov_q, ov_nxt, empty, take, pop;
    logic [DW-1:0] data_q;

    // Decide whether a stored word is taken and whether the output word is held.
    always_comb begin
        empty  = ((fbin_q ^ (fbin_q >> 1)) == wgray_sync);
        pop    = !cs_n && en && ov_q;
        take   = 1'b0;
        ov_nxt = ov_q;
        if (mode_std) begin
            take   = !cs_n && en && !empty;
            ov_nxt = 1'b0;
        end else begin
            take = !empty && (!ov_q || pop);
            if (take)     ov_nxt = 1'b1;
            else if (pop) ov_nxt = 1'b0;
        end
        fbin_nxt = fbin_q + PW'(take);
        cbin_nxt = fbin_nxt - PW'(ov_nxt);
    end

    // Update pointers, validity and the output word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fbin_q  <= '0;
            ov_q    <= 1'b0;
            rgray_q <= '0;
            data_q  <= '0;
        end else begin
            fbin_q  <= fbin_nxt;
            ov_q    <= ov_nxt;
            rgray_q <= cbin_nxt ^ (cbin_nxt >> 1);
            if (take) data_q <= mem_rdata;
        end
    end

    assign raddr = fbin_q[AW-1:0];
    assign rdata = data_q;
    assign rgray = rgray_q;
    assign flag  = mode_std ? empty : ov_q;
endmodule

// File: rtl/dmode_async_fifo.sv
// Dual-clock FIFO with standard and fall-through timing modes.
// Assumes: DEPTH is a power of two, at least 4; mode_std static from reset.
module dmode_async_fifo
    import dmf_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 16
) (
    input  logic          mode_std,
    input  logic          wclk,
    input  logic          wrst_n,
    input  logic          w_cs_n,
    input  logic          w_en,
    input  logic [DW-1:0] w_data,
    output logic          w_stat,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          r_cs_n,
    input  logic          r_en,
    output logic [DW-1:0] r_data,
    output logic          r_oe,
    output logic          r_stat
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    dmf_mode_e     mode_e;
    logic          is_std;
    logic          we;
    logic [AW-1:0] waddr, raddr;
    logic [PW-1:0] wptr_bin, wgray, rgray, wgray_rs, rgray_ws;
    logic [DW-1:0] mem_rdata;

    assign mode_e = dmf_mode_e'(mode_std);
    assign is_std = (mode_e == MODE_STD);
    assign r_oe   = !r_cs_n;

    dmf_wr_ctl #(.AW(AW)) u_wr (
        .clk(wclk), .rst_n(wrst_n), .mode_std(is_std),
        .cs_n(w_cs_n), .en(w_en), .rgray_sync(rgray_ws),
        .we(we), .waddr(waddr), .wbin(wptr_bin), .wgray(wgray), .flag(w_stat)
    );

    dmf_ram #(.DW(DW), .AW(AW)) u_ram (
        .wclk(wclk), .we(we), .waddr(waddr), .wdata(w_data),
        .raddr(raddr), .rdata(mem_rdata)
    );

    dmf_sync2 #(.W(PW)) u_w2r (
        .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_rs)
    );

    dmf_sync2 #(.W(PW)) u_r2w (
        .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_ws)
    );

    dmf_rd_ctl #(.DW(DW), .AW(AW)) u_rd (
        .clk(rclk), .rst_n(rrst_n), .mode_std(is_std),
        .cs_n(r_cs_n), .en(r_en), .wgray_sync(wgray_rs),
        .mem_rdata(mem_rdata), .raddr(raddr), .rdata(r_data),
        .rgray(rgray), .flag(r_stat)
    );
endmodule

// File: rtl/dmf_checker.sv
// Property checker for dmode_async_fifo, attached by bind.
// Assumes: pointers are PW bits wide; rgray_ws is the synchronized read pointer.
module dmf_checker #(
    parameter int DW    = 32,
    parameter int DEPTH = 16,
    parameter int PW    = 5
) (
    input logic          wclk,
    input logic          wrst_n,
    input logic          rclk,
    input logic          rrst_n,
    input logic          mode_std,
    input logic          w_cs_n,
    input logic          w_en,
    input logic          w_stat,
    input logic          r_cs_n,
    input logic          r_en,
    input logic          r_stat,
    input logic [DW-1:0] r_data,
    input logic [PW-1:0] wptr_bin,
    input logic [PW-1:0] rgray_ws,
    input logic [PW-1:0] rgray
);
    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [PW-1:0] level;
    assign level = wptr_bin - g2b(rgray_ws);

    AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!wrst_n)
        level <= PW'(DEPTH)); // R4
    AST_FULL_NO_WRITE: assert property (@(posedge wclk) disable iff (!wrst_n)
        (mode_std ? w_stat : !w_stat) |=> $stable(wptr_bin)); // R4
    AST_IDLE_NO_WRITE: assert property (@(posedge wclk) disable iff (!wrst_n)
        (w_cs_n || !w_en) |=> $stable(wptr_bin)); // R6
    AST_EMPTY_NO_READ: assert property (@(posedge rclk) disable iff (!rrst_n)
        (mode_std && r_stat) |=> $stable(rgray)); // R5
    AST_STD_DATA_HOLD: assert property (@(posedge rclk) disable iff (!rrst_n)
        (mode_std && (r_cs_n || !r_en || r_stat)) |=> $stable(r_data)); // R9
    AST_FWFT_WORD_HOLD: assert property (@(posedge rclk) disable iff (!rrst_n)
        (!mode_std && r_stat && (r_cs_n || !r_en)) |=> (r_stat && $stable(r_data))); // R3
endmodule

bind dmode_async_fifo dmf_checker #(.DW(DW), .DEPTH(DEPTH), .PW(PW)) u_chk (
    .wclk(wclk), .wrst_n(wrst_n), .rclk(rclk), .rrst_n(rrst_n),
    .mode_std(mode_std), .w_cs_n(w_cs_n), .w_en(w_en), .w_stat(w_stat),
    .r_cs_n(r_cs_n), .r_en(r_en), .r_stat(r_stat), .r_data(r_data),
    .wptr_bin(wptr_bin), .rgray_ws(rgray_ws), .rgray(rgray)
);

// File: tb/dmode_async_fifo_tb.sv
// Scoreboard bench: writer tasks queue expected words, a monitor pops and compares.
module dmode_async_fifo_tb;
    localparam int DW    = 32;
    localparam int DEPTH = 16;

    logic          mode_sel = 1'b1;
    logic          wclk = 1'b0, rclk = 1'b0;
    logic          wrst_n = 1'b0, rrst_n = 1'b0;
    logic          w_cs_n = 1'b1, w_en = 1'b0;
    logic [DW-1:0] w_data = '0;
    logic          r_cs_n = 1'b1, r_en = 1'b0;
    logic          w_stat, r_stat, r_oe;
    logic [DW-1:0] r_data;

    int            n_checks = 0;
    int            n_err    = 0;
    bit            mon_on   = 1'b0;
    bit            throttle = 1'b0;
    bit            done     = 1'b0;
    logic [DW-1:0] exp_q[$];

    always #5 wclk = ~wclk;
    always #7 rclk = ~rclk;

    dmode_async_fifo #(.DW(DW), .DEPTH(DEPTH)) u_dut (
        .mode_std(mode_sel), .wclk(wclk), .wrst_n(wrst_n),
        .w_cs_n(w_cs_n), .w_en(w_en), .w_data(w_data), .w_stat(w_stat),
        .rclk(rclk), .rrst_n(rrst_n), .r_cs_n(r_cs_n), .r_en(r_en),
        .r_data(r_data), .r_oe(r_oe), .r_stat(r_stat)
    );

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sb_compare(input string req);
        logic [DW-1:0] e;
        if (exp_q.size() == 0) begin
            check(1'b0, {req, " unexpected word"}, r_data, '0);
        end else begin
            e = exp_q.pop_front();
            check(r_data == e, req, r_data, e);
        end
    endtask

    task automatic do_reset(input logic mode);
        @(negedge wclk);
        wrst_n = 1'b0; rrst_n = 1'b0; mode_sel = mode;
        w_cs_n = 1'b1; w_en = 1'b0; r_cs_n = 1'b1; r_en = 1'b0;
        exp_q.delete();
        repeat (4) @(negedge rclk);
        wrst_n = 1'b1; rrst_n = 1'b1;
        repeat (2) @(negedge rclk);
    endtask

    // Attempt one write; queue the word only if the port reports it will be taken.
    task automatic put(input logic [DW-1:0] val, input logic cs_n, input logic en);
        bit acc;
        @(negedge wclk);
        w_cs_n = cs_n; w_en = en; w_data = val;
        acc = !cs_n && en && (mode_sel ? !w_stat : w_stat);
        @(posedge wclk);
        if (acc) exp_q.push_back(val);
    endtask

    task automatic put_burst(input int n, input logic [DW-1:0] base, input bit gaps);
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 4 == 3)) put(base + DW'(i) + 32'h100, 1'b0, 1'b0);
            put(base + DW'(i), 1'b0, 1'b1);
        end
        @(negedge wclk);
        w_en = 1'b0; w_cs_n = 1'b1;
    endtask

    task automatic stop_mon();
        mon_on = 1'b0;
        @(negedge rclk);
        #1 r_en = 1'b0; r_cs_n = 1'b1;
        repeat (2) @(negedge rclk);
    endtask

    task automatic drain(input string req);
        mon_on = 1'b1;
        for (int i = 0; i < 400; i++) begin
            if (exp_q.size() == 0) break;
            @(negedge rclk);
        end
        repeat (3) @(negedge rclk);
        stop_mon();
        check(exp_q.size() == 0, {req, " drain"}, DW'(exp_q.size()), '0);
        check(r_stat == mode_sel, {req, " idle flag after drain"}, DW'(r_stat), DW'(mode_sel));
    endtask

    // Monitor: issue reads when words are available and compare against the queue.
    initial begin
        bit pend = 1'b0;
        int cyc  = 0;
        forever begin
            @(negedge rclk);
            cyc++;
            if (pend) begin
                pend = 1'b0;
                sb_compare("R2/R9 standard read");
            end
            if (mon_on) begin
                if (throttle && (cyc % 3 == 0)) begin
                    r_en = 1'b0;
                end else if (mode_sel) begin
                    if (!r_stat) begin r_cs_n = 1'b0; r_en = 1'b1; pend = 1'b1; end
                    else r_en = 1'b0;
                end else begin
                    if (r_stat) begin
                        sb_compare("R3 fall-through word");
                        r_cs_n = 1'b0; r_en = 1'b1;
                    end else r_en = 1'b0;
                end
            end
        end
    end

    // Watchdog ends a hung run as a failure.
    initial begin
        #2000000;
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] held;

        // ---------------- standard mode ----------------
        do_reset(1'b1);
        check(r_stat == 1'b1, "R1 std empty after reset", DW'(r_stat), 1);
        check(w_stat == 1'b0, "R1 std not full after reset", DW'(w_stat), 0);
        check(r_oe == 1'b0, "R7 oe low while deselected", DW'(r_oe), 0);
        @(negedge rclk); r_cs_n = 1'b0;
        #1 check(r_oe == 1'b1, "R7 oe high while selected", DW'(r_oe), 1);
        r_cs_n = 1'b1;

        // R6: writes with select high or enable low must not enter
        put(32'hDEAD0001, 1'b1, 1'b1);
        put(32'hDEAD0002, 1'b0, 1'b0);
        put_burst(5, 32'hA0000000, 1'b0);
        repeat (6) @(negedge rclk);
        check(r_stat == 1'b0, "R2 not empty after writes", DW'(r_stat), 0);
        drain("R6 R2 std basic");

        // R5/R9: reads on an empty FIFO leave data and position untouched
        held = r_data;
        @(negedge rclk); r_cs_n = 1'b0; r_en = 1'b1;
        repeat (4) @(negedge rclk);
        check(r_data == held, "R5 R9 data held on empty read", r_data, held);
        check(r_stat == 1'b1, "R5 still empty", DW'(r_stat), 1);
        r_en = 1'b0; r_cs_n = 1'b1;
        put_burst(1, 32'hB0000000, 1'b0);
        drain("R5 position kept");

        // R2/R4: fill past capacity with reads idle
        put_burst(DEPTH + 3, 32'hC0000000, 1'b0);
        check(exp_q.size() == DEPTH, "R4 std accepted count", DW'(exp_q.size()), DW'(DEPTH));
        @(negedge wclk);
        check(w_stat == 1'b1, "R2 std full flag", DW'(w_stat), 1);
        drain("R4 std overfill");

        // R10: concurrent traffic, throttled reader
        throttle = 1'b1; mon_on = 1'b1;
        put_burst(40, 32'hD0000000, 1'b1);
        drain("R10 std stream");
        throttle = 1'b0;

        // ---------------- fall-through mode ----------------
        do_reset(1'b0);
        check(r_stat == 1'b0, "R1 fwft not ready after reset", DW'(r_stat), 0);
        check(w_stat == 1'b1, "R1 fwft room after reset", DW'(w_stat), 1);

        put_burst(1, 32'hE0000000, 1'b0);
        repeat (6) @(negedge rclk);
        check(r_stat == 1'b1, "R3 word ready without read", DW'(r_stat), 1);
        check(r_data == 32'hE0000000, "R3 word on output", r_data, 32'hE0000000);

        // R6: read enable with select high must not consume
        r_cs_n = 1'b1; r_en = 1'b1;
        repeat (4) @(negedge rclk);
        check(r_stat == 1'b1, "R6 fwft word kept", DW'(r_stat), 1);
        check(r_data == 32'hE0000000, "R6 fwft data kept", r_data, 32'hE0000000);
        r_en = 1'b0;
        drain("R3 fwft single");

        // R8/R4: output word counts toward capacity
        put_burst(DEPTH + 2, 32'hF0000000, 1'b0);
        check(exp_q.size() == DEPTH, "R8 fwft accepted count", DW'(exp_q.size()), DW'(DEPTH));
        repeat (10) @(negedge rclk);
        check(w_stat == 1'b0, "R8 fwft no room", DW'(w_stat), 0);
        check(r_stat == 1'b1, "R3 fwft first word ready", DW'(r_stat), 1);
        check(r_data == 32'hF0000000, "R3 fwft first word value", r_data, 32'hF0000000);
        drain("R4 fwft overfill");

        throttle = 1'b1; mon_on = 1'b1;
        put_burst(40, 32'h12340000, 1'b1);
        drain("R10 fwft stream");
        throttle = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule